// File: doc/BRIEF.md
# Descriptor Ring Completion Engine

This block is the device-side engine for one descriptor ring, either transmit or receive. The choice is made when the block is built. Software writes descriptors into a small internal descriptor store. It then publishes them by moving a head index through a register port. The engine walks the ring from its tail index in order. It only takes descriptors that software has marked as posted. For each such descriptor it offers one transfer at a time on a simple valid/done handshake.

On a transmit ring the offer carries the descriptor's buffer address, length and frame start/end codes. A done pulse means the frame has left. On a receive ring the offer says that a buffer is free. The done pulse then brings in the arriving frame's length and start/end codes. The engine writes these back into the descriptor. A frame longer than the configured limit is cut to the limit and marked as partial.

On every completion the engine sets the completed flag in the descriptor and moves the tail forward by one, modulo the descriptor count. If the descriptor asked for it, the engine also raises a one-cycle interrupt request. A control register enables the ring and selects raw mode. Clearing the enable bit stops the ring and returns both indices to zero.

Top module: `ring_engine`

## Requirements
- R1: After reset, every register reads zero (control, base, head, count, tail), `xfer_valid` is low and `irq_req` is low.
- R2: `xfer_valid` is high only when all of these hold: the ring is enabled, the count is nonzero, head differs from tail, and the descriptor at tail has the posted flag (value 0x4). While it is high, `xfer_addr`, `xfer_len`, `xfer_eof` and `xfer_sof` show that descriptor's fields. A descriptor is 128 bits: address [63:0], length [75:64], end code [79:76], start code [83:80], flags [95:84], time word [127:96].
- R3: A cycle with `xfer_done` high while `xfer_valid` is high completes exactly one descriptor. Tail moves by one and wraps from count-1 to 0. Tail changes at no other time except a stop.
- R4: On a transmit ring, a completion ORs the completed flag (0x2) into the descriptor's flags and leaves every other field unchanged.
- R5: On a receive ring, a frame no longer than the limit writes back its length, end code and start code. The resulting flags are: completed (0x2), plus the interrupt flag (0x8) if it was set, plus 0x1 when raw mode is off. The posted flag is cleared. A raw-mode frame that asked for an interrupt therefore ends with 0xA, and the same frame with raw mode off ends with 0xB.
- R6: On a receive ring, a frame longer than the limit writes back the limit as its length and keeps the posted flag, so a partial frame that asked for an interrupt ends with 0xE in raw mode. The limit is count register bits [31:16]. A field value of zero, or a value above 0x100, acts as 0x100.
- R7: `irq_req` is high for the one cycle after a completion, and only if that descriptor had the interrupt flag (0x8).
- R8: A descriptor at tail without the posted flag stalls the ring. `xfer_valid` stays low, `xfer_done` has no effect and tail holds. Once software sets the posted flag, the transfer is offered.
- R9: Writing the control register with bit 31 (enable) clear stops the ring. Head and tail return to 0, and `xfer_done` has no effect while the ring is disabled.
- R10: Register selector map: 0 control (bit 31 enable, bit 30 raw, bit 29 no-snoop, bit 28 flow control; all 32 bits stored), 1 base low, 2 base high, 3 head, 4 count (descriptor count in bits [15:0], capped at the store depth), 5 tail. Tail is read-only, so writes to selector 5 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write selector |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register read selector |
| reg_rdata | output | 32 | Register read data (combinational) |
| dsc_wr | input | 1 | Descriptor store write strobe |
| dsc_widx | input | IDX_W | Descriptor write index |
| dsc_wdata | input | 128 | Descriptor write data |
| dsc_ridx | input | IDX_W | Descriptor read index |
| dsc_rdata | output | 128 | Descriptor read data (combinational) |
| xfer_valid | output | 1 | Descriptor at tail is offered |
| xfer_addr | output | 64 | Buffer address of offered descriptor |
| xfer_len | output | 12 | Length of offered descriptor |
| xfer_eof | output | 4 | End code of offered descriptor |
| xfer_sof | output | 4 | Start code of offered descriptor |
| xfer_done | input | 1 | Frame finished for the offered descriptor |
| rx_len | input | 12 | Received frame length (receive ring) |
| rx_eof | input | 4 | Received end code (receive ring) |
| rx_sof | input | 4 | Received start code (receive ring) |
| irq_req | output | 1 | One-cycle completion interrupt request |

## Verification
A tail index that drifts from the true number of completions shows up on the selector-5 read at once. It also shows one cycle later as a completed flag written into the wrong slot, or as `xfer_valid` staying high on an empty ring. A wrong write-back decision (limit clamping, posted retention, raw-mode bit) can only be seen by reading the descriptor back after the done edge. So every completion in the bench is followed by a readback of its slot and a look at `irq_req` in that same cycle. Stall and stop faults show up as a tail that moves after a done pulse that should have been ignored.

// File: rtl/ring_eng_pkg.sv
package ring_eng_pkg;

   localparam int DESC_W = 128;

   typedef struct packed {
      logic [31:0] stamp;
      logic [11:0] flags;
      logic [3:0]  sof;
      logic [3:0]  eof;
      logic [11:0] len;
      logic [63:0] addr;
   } ring_desc_t;

   localparam logic [11:0] FL_ISO  = 12'h001;
   localparam logic [11:0] FL_DONE = 12'h002;
   localparam logic [11:0] FL_POST = 12'h004;
   localparam logic [11:0] FL_IRQ  = 12'h008;

   localparam int CB_EN  = 31;
   localparam int CB_RAW = 30;

   typedef enum logic [2:0] {
      RS_CTRL    = 3'd0,
      RS_BASE_LO = 3'd1,
      RS_BASE_HI = 3'd2,
      RS_HEAD    = 3'd3,
      RS_COUNT   = 3'd4,
      RS_TAIL    = 3'd5
   } reg_sel_e;

endpackage

// File: rtl/ring_desc_mem.sv
module ring_desc_mem
   import ring_eng_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_we,
   input  logic [IDX_W-1:0] sw_idx,
   input  ring_desc_t       sw_data,
   input  logic             eng_we,
   input  logic [IDX_W-1:0] eng_idx,
   input  ring_desc_t       eng_data,
   input  logic [IDX_W-1:0] rd0_idx,
   output ring_desc_t       rd0_data,
   input  logic [IDX_W-1:0] rd1_idx,
   output ring_desc_t       rd1_data
);

   localparam int DEPTH = 1 << IDX_W;

   ring_desc_t mem [DEPTH];

   // engine write-back wins a same-slot collision with software
   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (!rst_n)
            mem[i] <= '0;
         else if (eng_we && (eng_idx == IDX_W'(i)))
            mem[i] <= eng_data;
         else if (sw_we && (sw_idx == IDX_W'(i)))
            mem[i] <= sw_data;
      end
   end

   assign rd0_data = mem[rd0_idx];
   assign rd1_data = mem[rd1_idx];

endmodule

// File: rtl/ring_regs.sv
module ring_regs
   import ring_eng_pkg::*;
#(
   parameter int IDX_W     = 4,
   parameter bit IS_RX     = 1'b0,
   parameter int FRAME_CAP = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [2:0]       waddr,
   input  logic [31:0]      wdata,
   input  logic [2:0]       raddr,
   output logic [31:0]      rdata,
   input  logic [IDX_W-1:0] tail,
   output logic             enable,
   output logic             raw,
   output logic [IDX_W-1:0] head,
   output logic [IDX_W:0]   size,
   output logic [11:0]      limit,
   output logic             stop
);

   localparam int DEPTH = 1 << IDX_W;
   localparam logic [15:0] CAP16 = 16'(FRAME_CAP);

   logic [31:0]      ctrl_q, base_lo_q, base_hi_q, count_q;
   logic [IDX_W-1:0] head_q;

   assign stop = wr && (waddr == RS_CTRL) && !wdata[CB_EN];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         base_lo_q <= '0;
         base_hi_q <= '0;
         count_q   <= '0;
         head_q    <= '0;
      end else if (wr) begin
         case (waddr)
            RS_CTRL: begin
               ctrl_q <= wdata;
               if (!wdata[CB_EN]) head_q <= '0;
            end
            RS_BASE_LO: base_lo_q <= wdata;
            RS_BASE_HI: base_hi_q <= wdata;
            RS_HEAD:    head_q    <= wdata[IDX_W-1:0];
            RS_COUNT:   count_q   <= wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (raddr)
         RS_CTRL:    rdata = ctrl_q;
         RS_BASE_LO: rdata = base_lo_q;
         RS_BASE_HI: rdata = base_hi_q;
         RS_HEAD:    rdata = 32'(head_q);
         RS_COUNT:   rdata = count_q;
         RS_TAIL:    rdata = 32'(tail);
         default:    rdata = '0;
      endcase
   end

   assign enable = ctrl_q[CB_EN];
   assign raw    = ctrl_q[CB_RAW];
   assign head   = head_q;
   assign size   = (count_q[15:0] > 16'(DEPTH)) ? (IDX_W+1)'(DEPTH)
                                                : count_q[IDX_W:0];

   generate
      if (IS_RX) begin : g_rx_limit
         logic [15:0] fld;
         assign fld   = count_q[31:16];
         assign limit = ((fld == 16'd0) || (fld > CAP16)) ? CAP16[11:0] : fld[11:0];
      end else begin : g_tx_limit
         assign limit = CAP16[11:0];
      end
   endgenerate

   // R9: a stop write leaves head at zero
   a_r9_stop_head: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> (head_q == '0));

endmodule

// File: rtl/ring_complete.sv
module ring_complete
   import ring_eng_pkg::*;
#(
   parameter int IDX_W = 4,
   parameter bit IS_RX = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             raw,
   input  logic [IDX_W:0]   size,
   input  logic [IDX_W-1:0] head,
   input  logic [11:0]      limit,
   input  logic             stop,
   input  ring_desc_t       cur,
   input  logic             xfer_done,
   input  logic [11:0]      rx_len,
   input  logic [3:0]       rx_eof,
   input  logic [3:0]       rx_sof,
   output logic [IDX_W-1:0] tail,
   output logic             valid,
   output logic             wb_we,
   output ring_desc_t       wb_data,
   output logic             irq
);

   logic [IDX_W-1:0] tail_q, tail_nx;
   logic             irq_q, fire;
   logic [IDX_W:0]   inc;

   assign valid = enable && (size != '0) && (head != tail_q) && cur.flags[2];
   assign fire  = valid && xfer_done;
   assign inc   = {1'b0, tail_q} + 1'b1;
   assign tail_nx = (inc >= size) ? '0 : inc[IDX_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tail_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= fire && cur.flags[3];
         if (stop)
            tail_q <= '0;
         else if (fire)
            tail_q <= tail_nx;
      end
   end

   assign tail  = tail_q;
   assign irq   = irq_q;
   assign wb_we = fire;

   generate
      if (IS_RX) begin : g_rx
         logic partial;
         assign partial = rx_len > limit;
         always_comb begin
            wb_data       = cur;
            wb_data.len   = partial ? limit : rx_len;
            wb_data.eof   = rx_eof;
            wb_data.sof   = rx_sof;
            wb_data.flags = FL_DONE | (cur.flags & FL_IRQ)
                          | (partial ? FL_POST : 12'h0)
                          | (raw ? 12'h0 : FL_ISO);
         end
         // R6: written length never exceeds the active limit
         a_r6_len_clamped: assert property (@(posedge clk) disable iff (!rst_n)
            wb_we |-> (wb_data.len <= limit));
      end else begin : g_tx
         always_comb begin
            wb_data       = cur;
            wb_data.flags = cur.flags | FL_DONE;
         end
      end
   endgenerate

   // R3: tail moves only on a completion or a stop
   a_r3_tail_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!fire && !stop) |=> $stable(tail_q));

endmodule

// File: rtl/ring_engine.sv
module ring_engine
   import ring_eng_pkg::*;
#(
   parameter bit IS_RX     = 1'b0,
   parameter int IDX_W     = 4,
   parameter int FRAME_CAP = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [2:0]       reg_waddr,
   input  logic [31:0]      reg_wdata,
   input  logic [2:0]       reg_raddr,
   output logic [31:0]      reg_rdata,
   input  logic             dsc_wr,
   input  logic [IDX_W-1:0] dsc_widx,
   input  logic [127:0]     dsc_wdata,
   input  logic [IDX_W-1:0] dsc_ridx,
   output logic [127:0]     dsc_rdata,
   output logic             xfer_valid,
   output logic [63:0]      xfer_addr,
   output logic [11:0]      xfer_len,
   output logic [3:0]       xfer_eof,
   output logic [3:0]       xfer_sof,
   input  logic             xfer_done,
   input  logic [11:0]      rx_len,
   input  logic [3:0]       rx_eof,
   input  logic [3:0]       rx_sof,
   output logic             irq_req
);

   generate
      if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
         $error("ring_engine: IDX_W must lie in 1..12");
      end
      if (FRAME_CAP < 1 || FRAME_CAP > 4095) begin : g_bad_cap
         $error("ring_engine: FRAME_CAP must fit the 12-bit length field");
      end
   endgenerate

   logic             en_w, raw_w, stop_w, wb_we_w;
   logic [IDX_W-1:0] head_w, tail_w;
   logic [IDX_W:0]   size_w;
   logic [11:0]      limit_w;
   ring_desc_t       cur_w, wb_w, rd1_w;

   ring_regs #(.IDX_W(IDX_W), .IS_RX(IS_RX), .FRAME_CAP(FRAME_CAP)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr(reg_wr), .waddr(reg_waddr), .wdata(reg_wdata),
      .raddr(reg_raddr), .rdata(reg_rdata),
      .tail(tail_w), .enable(en_w), .raw(raw_w), .head(head_w),
      .size(size_w), .limit(limit_w), .stop(stop_w)
   );

   ring_desc_mem #(.IDX_W(IDX_W)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .sw_we(dsc_wr), .sw_idx(dsc_widx), .sw_data(ring_desc_t'(dsc_wdata)),
      .eng_we(wb_we_w), .eng_idx(tail_w), .eng_data(wb_w),
      .rd0_idx(tail_w), .rd0_data(cur_w),
      .rd1_idx(dsc_ridx), .rd1_data(rd1_w)
   );

   ring_complete #(.IDX_W(IDX_W), .IS_RX(IS_RX)) u_cmp (
      .clk(clk), .rst_n(rst_n),
      .enable(en_w), .raw(raw_w), .size(size_w), .head(head_w),
      .limit(limit_w), .stop(stop_w), .cur(cur_w),
      .xfer_done(xfer_done), .rx_len(rx_len), .rx_eof(rx_eof), .rx_sof(rx_sof),
      .tail(tail_w), .valid(xfer_valid), .wb_we(wb_we_w), .wb_data(wb_w),
      .irq(irq_req)
   );

   assign dsc_rdata = rd1_w;
   assign xfer_addr = cur_w.addr;
   assign xfer_len  = cur_w.len;
   assign xfer_eof  = cur_w.eof;
   assign xfer_sof  = cur_w.sof;

   // R2: nothing is offered from an empty ring
   a_r2_valid_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid |-> (tail_w != head_w));

   // R9: a disabled ring offers nothing
   a_r9_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !en_w |-> !xfer_valid);

   // R7: an interrupt request follows a completion handshake
   a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> $past(xfer_done && xfer_valid));

   // R2: an offered descriptor carries the posted flag
   a_r2_offer_posted: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid |-> cur_w.flags[2]);

endmodule

// File: tb/tb_ring_engine.sv
`timescale 1ns/1ps
module tb_ring_engine;

   localparam int IDX_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic             reg_wr = 0;
   logic [2:0]       reg_waddr = 0, reg_raddr = 0;
   logic [31:0]      reg_wdata = 0;
   logic             dsc_wr = 0;
   logic [IDX_W-1:0] dsc_widx = 0, dsc_ridx = 0;
   logic [127:0]     dsc_wdata = 0;
   logic             xfer_done = 0;
   logic [11:0]      rx_len = 0;
   logic [3:0]       rx_eof = 0, rx_sof = 0;

   logic [31:0]  rd_rx, rd_tx;
   logic [127:0] drd_rx, drd_tx;
   logic         v_rx, v_tx, irq_rx, irq_tx;
   logic [63:0]  a_rx, a_tx;
   logic [11:0]  l_rx, l_tx;
   logic [3:0]   e_rx, e_tx, s_rx, s_tx;

   ring_engine #(.IS_RX(1'b1), .IDX_W(IDX_W)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
      .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(rd_rx),
      .dsc_wr(dsc_wr), .dsc_widx(dsc_widx), .dsc_wdata(dsc_wdata),
      .dsc_ridx(dsc_ridx), .dsc_rdata(drd_rx), .xfer_valid(v_rx),
      .xfer_addr(a_rx), .xfer_len(l_rx), .xfer_eof(e_rx), .xfer_sof(s_rx),
      .xfer_done(xfer_done), .rx_len(rx_len), .rx_eof(rx_eof), .rx_sof(rx_sof),
      .irq_req(irq_rx));

   ring_engine #(.IS_RX(1'b0), .IDX_W(IDX_W)) dut_tx (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
      .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(rd_tx),
      .dsc_wr(dsc_wr), .dsc_widx(dsc_widx), .dsc_wdata(dsc_wdata),
      .dsc_ridx(dsc_ridx), .dsc_rdata(drd_tx), .xfer_valid(v_tx),
      .xfer_addr(a_tx), .xfer_len(l_tx), .xfer_eof(e_tx), .xfer_sof(s_tx),
      .xfer_done(xfer_done), .rx_len(rx_len), .rx_eof(rx_eof), .rx_sof(rx_sof),
      .irq_req(irq_tx));

   int errors = 0;
   int checks = 0;

   typedef struct packed {
      logic [11:0] fl;
      logic [11:0] rlen;
      logic [3:0]  reof;
      logic [3:0]  rsof;
      logic [11:0] xfl_rx;
      logic [11:0] xlen;
      logic        xirq;
      logic [11:0] xfl_tx;
   } vec_t;

   // limit 0x80, raw mode on
   localparam vec_t VT [0:4] = '{
      '{12'hC, 12'h040, 4'd1, 4'd0, 12'hA, 12'h040, 1'b1, 12'hE},
      '{12'h4, 12'h080, 4'd2, 4'd0, 12'h2, 12'h080, 1'b0, 12'h6},
      '{12'hC, 12'h081, 4'd3, 4'd1, 12'hE, 12'h080, 1'b1, 12'hE},
      '{12'h4, 12'h100, 4'd4, 4'd0, 12'h6, 12'h080, 1'b0, 12'h6},
      '{12'hD, 12'h010, 4'd5, 4'd2, 12'hA, 12'h010, 1'b1, 12'hF}
   };

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wreg(input logic [2:0] sel, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1; reg_waddr = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic rreg_rx(input logic [2:0] sel, output logic [31:0] v);
      reg_raddr = sel; #1; v = rd_rx;
   endtask

   task automatic wdsc(input int idx, input logic [11:0] fl, input logic [11:0] len,
                       input logic [63:0] addr);
      @(negedge clk);
      dsc_wr = 1; dsc_widx = IDX_W'(idx);
      dsc_wdata = {32'h0, fl, 4'h6, 4'h9, len, addr};
      @(negedge clk);
      dsc_wr = 0;
   endtask

   task automatic done(input logic [11:0] l, input logic [3:0] e, input logic [3:0] s);
      @(negedge clk);
      xfer_done = 1; rx_len = l; rx_eof = e; rx_sof = s;
      @(negedge clk);
      xfer_done = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      for (int s = 0; s < 6; s++) begin
         rreg_rx(3'(s), r);
         chk("R1 register zero", 128'(r), 128'h0);
      end
      chk("R1 valid low", 128'(v_rx), 128'h0);
      chk("R1 irq low", 128'(irq_rx), 128'h0);

      // R10 register map
      wreg(3'd1, 32'h1234_5678);
      wreg(3'd2, 32'h9ABC_DEF0);
      rreg_rx(3'd1, r); chk("R10 base lo", 128'(r), 128'h1234_5678);
      rreg_rx(3'd2, r); chk("R10 base hi", 128'(r), 128'h9ABC_DEF0);
      wreg(3'd0, 32'hF000_0000);
      rreg_rx(3'd0, r); chk("R10 ctrl bits", 128'(r), 128'hF000_0000);
      wreg(3'd0, 32'hC000_0000);
      wreg(3'd4, 32'h0080_0008);
      rreg_rx(3'd4, r); chk("R10 count", 128'(r), 128'h0080_0008);

      // table walk: ten completions over an 8-entry ring, wrapping once
      for (int k = 0; k < 10; k++) begin
         vec_t v;
         int idx;
         logic [63:0] ad;
         v = VT[k % 5];
         idx = k % 8;
         ad = 64'hA000_0000_0000_0000 + 64'(k) * 64'h40;
         wdsc(idx, v.fl, 12'h100 + 12'(k), ad);
         wreg(3'd3, 32'((k + 1) % 8));
         chk("R2 valid rx", 128'(v_rx), 128'h1);
         chk("R2 valid tx", 128'(v_tx), 128'h1);
         chk("R2 address", 128'(a_tx), 128'(ad));
         chk("R2 length", 128'(l_tx), 128'(12'h100 + 12'(k)));
         chk("R2 codes", 128'({e_tx, s_tx}), 128'h96);
         done(v.rlen, v.reof, v.rsof);
         chk("R7 irq rx", 128'(irq_rx), 128'(v.xirq));
         chk("R7 irq tx", 128'(irq_tx), 128'(v.xirq));
         dsc_ridx = IDX_W'(idx); #1;
         chk(v.rlen > 12'h80 ? "R6 partial flags" : "R5 rx flags",
             128'(drd_rx[95:84]), 128'(v.xfl_rx));
         chk(v.rlen > 12'h80 ? "R6 partial length" : "R5 rx length",
             128'(drd_rx[75:64]), 128'(v.xlen));
         chk("R5 rx codes", 128'({drd_rx[83:80], drd_rx[79:76]}),
             128'({v.rsof, v.reof}));
         chk("R4 tx flags", 128'(drd_tx[95:84]), 128'(v.xfl_tx));
         chk("R4 tx fields kept", 128'(drd_tx[83:0]),
             128'({4'h6, 4'h9, 12'h100 + 12'(k), ad}));
         rreg_rx(3'd5, r);
         chk("R3 tail advance/wrap", 128'(r), 128'((k + 1) % 8));
         chk("R3 one per handshake", 128'(v_rx), 128'h0);
      end

      // R6 limit field zero acts as 0x100 (tail at 2)
      wreg(3'd4, 32'h0000_0008);
      wdsc(2, 12'hC, 12'h0, 64'h0);
      wreg(3'd3, 32'd3);
      done(12'h101, 4'd1, 4'd0);
      dsc_ridx = 2; #1;
      chk("R6 zero limit length", 128'(drd_rx[75:64]), 128'h100);
      chk("R6 zero limit flags", 128'(drd_rx[95:84]), 128'hE);

      // R5 raw mode off gives 0xB
      wreg(3'd0, 32'h8000_0000);
      wdsc(3, 12'hC, 12'h0, 64'h0);
      wreg(3'd3, 32'd4);
      done(12'h020, 4'd1, 4'd0);
      dsc_ridx = 3; #1;
      chk("R5 non-raw flags", 128'(drd_rx[95:84]), 128'hB);

      // R8 unposted descriptor stalls
      wdsc(4, 12'h8, 12'h0, 64'h0);
      wreg(3'd3, 32'd5);
      chk("R8 stall valid", 128'(v_rx), 128'h0);
      done(12'h010, 4'd1, 4'd0);
      chk("R8 stall irq", 128'(irq_rx), 128'h0);
      rreg_rx(3'd5, r); chk("R8 stall tail", 128'(r), 128'h4);
      dsc_ridx = 4; #1;
      chk("R8 stall flags untouched", 128'(drd_rx[95:84]), 128'h8);
      wdsc(4, 12'hC, 12'h0, 64'h0);
      chk("R8 released", 128'(v_rx), 128'h1);

      // R9 stop
      wreg(3'd0, 32'h0);
      rreg_rx(3'd3, r); chk("R9 head zero", 128'(r), 128'h0);
      rreg_rx(3'd5, r); chk("R9 tail zero", 128'(r), 128'h0);
      chk("R9 valid low", 128'(v_rx), 128'h0);
      wreg(3'd3, 32'd2);
      done(12'h010, 4'd1, 4'd0);
      rreg_rx(3'd5, r); chk("R9 disabled done ignored", 128'(r), 128'h0);

      // R10 tail is read-only
      wreg(3'd5, 32'd3);
      rreg_rx(3'd5, r); chk("R10 tail write ignored", 128'(r), 128'h0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule